// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Writes

This block holds a 256-entry colour lookup table, each entry a red, green and blue byte. Software reaches it through a small 16-byte register window on a 32-bit bus. One register selects the entry to work on. Successive writes to a second register fill that entry's red, then green, then blue byte. After the blue byte the selected entry moves on to the next one by itself, so a whole palette can be loaded as one stream of data writes.

A separate read port serves the display path. It takes an 8-bit pixel code and returns the 24-bit colour one clock later. A one-cycle flag marks every accepted component write, so that downstream logic knows the screen must be redrawn.

Top module: `clut_regs`

## Requirements
- R1: After reset every entry reads as 24'h000000 except entry 255, which reads as 24'hFFFFFF. The selected entry and the component phase both start at zero (red of entry 0).
- R2: A full-width write to byte offset 0 loads the selected entry from bus_wdata[31:24] and returns the phase to red, even partway through an entry.
- R3: A full-width write to byte offset 4 stores bus_wdata[31:24] into the current component of the selected entry and advances the phase from red to green to blue. The lookup result packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: The blue write advances the selected entry by one modulo 256 (255 goes to 0) and returns the phase to red.
- R5: bus_rdata is zero at all times, and a read access (bus_we low) changes neither the table, the selected entry nor the phase.
- R6: A write whose byte enables are not all four set (bus_be other than 4'b1111) is ignored.
- R7: Writes to byte offsets other than 0 and 4 inside the window are ignored and leave the selected entry and the phase as they were.
- R8: pix_rgb shows the entry addressed by pix_idx one clock later. When a component write and a lookup hit the same entry in the same cycle, the lookup returns the value from before the write.
- R9: pal_changed is high for exactly the one cycle after each accepted component write and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access to the register window this cycle |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Colour of pix_idx from the previous cycle, {red, green, blue} |
| pal_changed | output | 1 | One-cycle flag after each accepted component write |

## Verification
The assertions take it as given that the bus inputs are held at known values, low or idle, while reset is asserted. Their past-value checks in the first cycle after reset rely on this. They also take it as given that an access lasts one cycle, so each cycle with bus_sel high counts as its own access. The stimulus drives every access for exactly one cycle from the falling edge. It keeps every bus input at zero through each reset. Rejected accesses, such as a partial byte-enable write or an unused offset, are placed between the accepted writes of one entry, so the bench sees at once whether the phase moved.

// File: rtl/clut_regs.sv
module clut_regs #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [3:0]          bus_addr,
  input  logic [3:0]          bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb,
  output logic                pal_changed
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int RGB_W   = 3 * COMP_W;
  localparam logic [3:0] OFS_INDEX = 4'h0;
  localparam logic [3:0] OFS_DATA  = 4'h4;
  localparam logic [1:0] PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2;

  logic [RGB_W-1:0]  table_q [ENTRIES];
  logic [IDX_W-1:0]  idx;
  logic [1:0]        phase;
  logic [COMP_W-1:0] top_byte;
  logic              wr_ok, idx_wr, dat_wr;

  assign top_byte  = bus_wdata[DATA_W-1 -: COMP_W];
  assign wr_ok     = bus_sel && bus_we && (bus_be == 4'b1111);
  assign idx_wr    = wr_ok && (bus_addr == OFS_INDEX);
  assign dat_wr    = wr_ok && (bus_addr == OFS_DATA);
  assign bus_rdata = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_R;
    end else if (idx_wr) begin
      idx   <= top_byte[IDX_W-1:0];
      phase <= PH_R;
    end else if (dat_wr) begin
      if (phase == PH_B) begin
        idx   <= idx + 1'b1;
        phase <= PH_R;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        table_q[i] <= (i == ENTRIES - 1) ? {RGB_W{1'b1}} : '0;
    end else if (dat_wr) begin
      case (phase)
        PH_R:    table_q[idx][3*COMP_W-1 -: COMP_W] <= top_byte;
        PH_G:    table_q[idx][2*COMP_W-1 -: COMP_W] <= top_byte;
        default: table_q[idx][COMP_W-1 -: COMP_W]   <= top_byte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_rgb     <= '0;
      pal_changed <= 1'b0;
    end else begin
      pix_rgb     <= table_q[pix_idx];
      pal_changed <= dat_wr;
    end
  end
endmodule

// File: rtl/clut_regs_chk.sv
module clut_regs_chk #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [3:0]        bus_addr,
  input logic [3:0]        bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IDX_W-1:0]  idx,
  input logic [1:0]        phase,
  input logic              pal_changed
);
  logic full_wr;
  assign full_wr = bus_sel && bus_we && (bus_be == 4'b1111);

  p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == 4'h0) |=>
      (idx == $past(bus_wdata[DATA_W-1 -: IDX_W]) && phase == 2'd0));

  p_blue_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && bus_addr == 4'h4 && phase == 2'd2) |=>
      (idx == $past(idx) + 1'b1 && phase == 2'd0));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  p_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == '0);

  p_partial_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_be != 4'b1111) |=> ($stable(idx) && $stable(phase)));

  p_other_ofs_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr != 4'h0 && bus_addr != 4'h4) |=> ($stable(idx) && $stable(phase)));

  p_changed_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pal_changed |-> $past(full_wr && bus_addr == 4'h4));
endmodule

bind clut_regs clut_regs_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .idx(idx), .phase(phase), .pal_changed(pal_changed)
);

// File: tb/clut_regs_tb_top.sv
module clut_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        pal_changed;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  clut_regs dut_i (.*);

  // {addr, be, top byte, lookup index, expected colour}
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {4'h0, 4'hF, 8'h10, 8'h10, 24'h000000},
    {4'h4, 4'hF, 8'h11, 8'h10, 24'h110000},
    {4'h4, 4'hF, 8'h22, 8'h10, 24'h112200},
    {4'h4, 4'hF, 8'h33, 8'h10, 24'h112233},
    {4'h4, 4'hF, 8'h44, 8'h11, 24'h440000},
    {4'h8, 4'hF, 8'hFF, 8'h11, 24'h440000},
    {4'h4, 4'hF, 8'h55, 8'h11, 24'h445500},
    {4'h4, 4'h7, 8'h99, 8'h11, 24'h445500},
    {4'hC, 4'hF, 8'h00, 8'h11, 24'h445500},
    {4'h0, 4'hE, 8'h30, 8'h11, 24'h445500},
    {4'h4, 4'hF, 8'h66, 8'h11, 24'h445566},
    {4'h0, 4'hF, 8'h20, 8'h20, 24'h000000},
    {4'h4, 4'hF, 8'hAA, 8'h20, 24'hAA0000},
    {4'h0, 4'hF, 8'h20, 8'h20, 24'hAA0000},
    {4'h4, 4'hF, 8'hBB, 8'h20, 24'hBB0000},
    {4'h4, 4'hF, 8'hCC, 8'h20, 24'hBBCC00},
    {4'h0, 4'hF, 8'hFF, 8'hFF, 24'hFFFFFF},
    {4'h4, 4'hF, 8'h01, 8'hFF, 24'h01FFFF},
    {4'h4, 4'hF, 8'h02, 8'hFF, 24'h0102FF},
    {4'h4, 4'hF, 8'h03, 8'hFF, 24'h010203},
    {4'h4, 4'hF, 8'h07, 8'h00, 24'h070000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_acc(input logic we, input logic [3:0] a, input logic [3:0] be,
                         input logic [7:0] d, output logic chg);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = {d, 24'h5A5A5A};
    @(negedge clk);
    chg = pal_changed;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic lookup(input logic [7:0] i, output logic [23:0] c);
    @(negedge clk);
    pix_idx = i;
    @(negedge clk);
    c = pix_rgb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] c;
    logic chg;
    do_reset();
    // R1 reset contents
    lookup(8'h00, c); check("R1 entry 0", {8'h0, c}, 32'h0);
    lookup(8'h80, c); check("R1 entry 128", {8'h0, c}, 32'h0);
    lookup(8'hFE, c); check("R1 entry 254", {8'h0, c}, 32'h0);
    lookup(8'hFF, c); check("R1 entry 255", {8'h0, c}, 32'h00FFFFFF);
    check("R9 idle after reset", {31'h0, pal_changed}, 32'h0);

    // R2 R3 R4 R6 R7 R9 vector walk
    for (int k = 0; k < NV; k++) begin
      logic [47:0] v;
      v = VEC[k];
      bus_acc(1'b1, v[47:44], v[43:40], v[39:32], chg);
      check("R9 change flag", {31'h0, chg},
            {31'h0, (v[47:44] == 4'h4 && v[43:40] == 4'hF)});
      lookup(v[31:24], c);
      check("R2/R3/R4/R6/R7 entry", {8'h0, c}, {8'h0, v[23:0]});
    end
    check("R9 flag single cycle", {31'h0, pal_changed}, 32'h0);

    // R5 reads return zero, do not write
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'h4; bus_be = 4'hF; bus_wdata = 32'hEE00_0000;
    #1 check("R5 read data", bus_rdata, 32'h0);
    bus_acc(1'b0, 4'h0, 4'hF, 8'h00, chg);
    check("R5 read no flag", {31'h0, chg}, 32'h0);
    // idx is 0, phase green: next data lands in green of entry 0
    bus_acc(1'b1, 4'h4, 4'hF, 8'h08, chg);
    lookup(8'h00, c); check("R5 read left phase", {8'h0, c}, 32'h00070800);

    // R8 same-cycle write and lookup return old value
    @(negedge clk);
    pix_idx = 8'h00;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_be = 4'hF; bus_wdata = 32'h0900_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    check("R8 old value same cycle", {8'h0, pix_rgb}, 32'h00070800);
    @(negedge clk);
    check("R8 new value next cycle", {8'h0, pix_rgb}, 32'h00070809);

    // R1 reset clears index and phase mid-entry
    bus_acc(1'b1, 4'h0, 4'hF, 8'h40, chg);
    bus_acc(1'b1, 4'h4, 4'hF, 8'h41, chg);
    do_reset();
    lookup(8'h40, c); check("R1 table cleared", {8'h0, c}, 32'h0);
    bus_acc(1'b1, 4'h4, 4'hF, 8'h5A, chg);
    lookup(8'h00, c); check("R1 index and phase cleared", {8'h0, c}, 32'h005A0000);
    lookup(8'hFF, c); check("R1 white entry restored", {8'h0, c}, 32'h00FFFFFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule